// File: doc/BRIEF.md
# Power-State Sequencing Controller

This block is the digital state machine of a multi-rail power management unit. It watches three supply and temperature flags from analog comparators: supply above the power-on-reset level, supply below the undervoltage-lockout falling level, and over-temperature. It also watches the external enable pin, a power-good flag from each of three regulators, and a small local register file written by a host over a serial bus. From these it moves through six power states, switches the regulators on in a fixed order, and drives the level of a shutdown-indicator pin. All asynchronous inputs pass through two-flop synchronizers before any decision uses them.

Register writes arrive on a valid/ready port. A write completes on a cycle where `wr_valid` and `wr_ready` are both high. The block lowers `wr_ready` while it is unpowered or running its internal reset, and a held write waits until the block is ready. Reads are combinational on `rd_addr`. An undervoltage lockout switches every regulator off at once but keeps register contents. Only a supply drop below the power-on-reset level returns the registers to their defaults.

The state code on `state_o` is: 0 unpowered, 1 internal reset, 2 standby, 3 start-up sequencing, 4 running, 5 thermal shutdown.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While the synchronized POR flag is low, `state_o` is 0, `rail_en` is 0, `wr_ready` is 0 and `rf_clear` is 1. This is also the state after `rst_n` is released.
- R2: When the POR flag goes high, the block enters state 1 and stays there for RST_CYC cycles. It then enters standby (state 2).
- R3: An enable request starts sequencing (state 3). The request is the EN pin high or bit 0 of the control register at address 0x01 set. Regulators switch on in the order 1, 2, 3, so `rail_en` takes the values 001, 011, 111. Each step waits for the power-good flag of the regulator just enabled.
- R4: When the last regulator reports power good, the block enters state 4 with `rail_en` = 111.
- R5: In a step, if power good stays low for more than the value of the timeout register (address 0x02, default 200) in cycles, the block returns to standby with all rails off. It does not restart until the enable request has gone low once.
- R6: In state 3 or 4, the block returns to standby and switches every rail off when either of two things happens: the enable request drops (EN low and the 0x01 bit 0 cleared, which is the off command), or the UVLO flag is high. Register contents are kept.
- R7: A POR drop from any state returns every register to its default: 0x01 = 0, 0x02 = 200, bit 0 of 0x03 = 0.
- R8: An over-temperature flag in states 2 to 4 enters state 5 with all rails off. When the flag clears, the block returns to standby with registers kept.
- R9: The indicator pin is 1 only when all rails are on and all power-good flags are high, and one more condition holds. With EN high, that condition is met and FORCE is ignored. With EN low, the 0x01 enable bit and FORCE (0x03 bit 0) must both be 1. In every other case the pin is 0.
- R10: Register 0x03 reads bits [3:1] as the synchronized power-good flags of regulators 3..1 and bit 0 as FORCE. Only bit 0 is writable. Writes to unmapped addresses (such as 0x00) are ignored, and those addresses read 0.
- R11: `wr_ready` is 1 in states 2 to 5 and 0 in states 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the digital logic |
| por_ok_a | input | 1 | Supply above POR level (asynchronous) |
| uvlo_a | input | 1 | Supply below UVLO falling level (asynchronous) |
| tsd_a | input | 1 | Over-temperature flag (asynchronous) |
| en_pin_a | input | 1 | External enable pin (asynchronous) |
| pg_a | input | 3 | Power-good flags of regulators 3..1 (asynchronous) |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Block accepts register writes |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| rail_en | output | 3 | Regulator enables 3..1 |
| rf_clear | output | 1 | Register file held at defaults |
| xs_pin | output | 1 | Shutdown-indicator pin level |
| state_o | output | 3 | Current power state code |

## Verification
The hardest case to reach from the ports is the sequencing timeout and the latch that blocks restart after it. The regulators must be kept from reporting power good while the enable request stays high. To do this, the bench stops its power-good model from following `rail_en` and holds the flags low by hand. It programs a short timeout, waits past it, and confirms that standby persists. It then drops the enable and raises it again with the model following the rails, to show the latch has cleared. The ordering check uses the same manual override: each power-good is released one at a time, and `rail_en` must not advance before its turn.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_INIT = 3'd1,
    PS_IDLE = 3'd2,
    PS_SEQ  = 3'd3,
    PS_RUN  = 3'd4,
    PS_HOT  = 3'd5
  } pstate_t;

  localparam int SLOT_CTRL = 1;
  localparam int SLOT_TMO  = 2;
  localparam int SLOT_STAT = 3;
  localparam int NSLOT     = 4;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q_s
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_a;
      else chain[s] <= chain[(s == 0) ? 0 : s - 1];
    end
  end

  assign q_s = chain[STAGES-1];
endmodule

// File: rtl/pwr_regfile.sv
module pwr_regfile import pwr_seq_pkg::*; #(
  parameter int         NRAIL   = 3,
  parameter int         AW      = 8,
  parameter int         DW      = 8,
  parameter logic [7:0] DEF_TMO = 8'd200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_fire,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NRAIL-1:0] pg_s,
  output logic [DW-1:0]    rd_data,
  output logic             all_on,
  output logic [7:0]       tmo,
  output logic             force_xs
);
  logic [DW-1:0] mem [NSLOT];

  function automatic logic [DW-1:0] wmask(input int idx);
    case (idx)
      SLOT_CTRL: return DW'(1);
      SLOT_TMO:  return DW'(8'hFF);
      SLOT_STAT: return DW'(1);
      default:   return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] defval(input int idx);
    return (idx == SLOT_TMO) ? DW'(DEF_TMO) : '0;
  endfunction

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= defval(g);
      else if (clr)
        mem[g] <= defval(g);
      else if (wr_fire && wr_addr == AW'(g))
        mem[g] <= (mem[g] & ~wmask(g)) | (wr_data & wmask(g));
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rd_addr == AW'(i)) begin
        rd_data = mem[i];
        if (i == SLOT_STAT) rd_data[NRAIL:1] = pg_s;
      end
    end
  end

  assign all_on   = mem[SLOT_CTRL][0];
  assign tmo      = mem[SLOT_TMO][7:0];
  assign force_xs = mem[SLOT_STAT][0];
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm import pwr_seq_pkg::*; #(
  parameter int NRAIL   = 3,
  parameter int RST_CYC = 16,
  parameter int TW      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_s,
  input  logic             uvlo_s,
  input  logic             tsd_s,
  input  logic             en_req,
  input  logic [NRAIL-1:0] pg_s,
  input  logic [TW-1:0]    tmo,
  output pstate_t          state_q,
  output logic [NRAIL-1:0] rail_en
);
  localparam int SW  = (NRAIL > 1) ? $clog2(NRAIL) : 1;
  localparam int RCW = $clog2(RST_CYC + 1);

  logic [SW-1:0]  step_q, step_n;
  logic [TW-1:0]  timer_q, timer_n;
  logic [RCW-1:0] rcnt_q, rcnt_n;
  logic           fail_q, fail_n;
  pstate_t        state_n;
  logic [NRAIL-1:0] rail_n;

  always_comb begin
    state_n = state_q;
    step_n  = step_q;
    timer_n = timer_q;
    rcnt_n  = rcnt_q;
    fail_n  = fail_q;
    if (!por_s) begin
      state_n = PS_OFF;
      rcnt_n  = '0;
      fail_n  = 1'b0;
    end else if (tsd_s && (state_q == PS_IDLE || state_q == PS_SEQ || state_q == PS_RUN)) begin
      state_n = PS_HOT;
    end else begin
      case (state_q)
        PS_OFF: begin
          state_n = PS_INIT;
          rcnt_n  = '0;
        end
        PS_INIT: begin
          if (rcnt_q == RCW'(RST_CYC - 1)) state_n = PS_IDLE;
          else rcnt_n = rcnt_q + 1'b1;
        end
        PS_IDLE: begin
          if (!en_req) fail_n = 1'b0;
          if (en_req && !fail_q && !uvlo_s) begin
            state_n = PS_SEQ;
            step_n  = '0;
            timer_n = '0;
          end
        end
        PS_SEQ: begin
          if (uvlo_s || !en_req) begin
            state_n = PS_IDLE;
          end else if (pg_s[step_q]) begin
            timer_n = '0;
            if (int'(step_q) == NRAIL - 1) state_n = PS_RUN;
            else step_n = step_q + 1'b1;
          end else if (timer_q == tmo) begin
            state_n = PS_IDLE;
            fail_n  = 1'b1;
          end else begin
            timer_n = timer_q + 1'b1;
          end
        end
        PS_RUN: begin
          if (uvlo_s || !en_req) state_n = PS_IDLE;
        end
        PS_HOT: begin
          if (!tsd_s) state_n = PS_IDLE;
        end
        default: state_n = PS_OFF;
      endcase
    end
  end

  always_comb begin
    rail_n = '0;
    if (state_n == PS_RUN) begin
      rail_n = '1;
    end else if (state_n == PS_SEQ) begin
      for (int i = 0; i < NRAIL; i++) rail_n[i] = (i <= int'(step_n));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      step_q  <= '0;
      timer_q <= '0;
      rcnt_q  <= '0;
      fail_q  <= 1'b0;
      rail_en <= '0;
    end else begin
      state_q <= state_n;
      step_q  <= step_n;
      timer_q <= timer_n;
      rcnt_q  <= rcnt_n;
      fail_q  <= fail_n;
      rail_en <= rail_n;
    end
  end
endmodule

// File: rtl/pwr_xs_drive.sv
module pwr_xs_drive #(
  parameter int NRAIL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_s,
  input  logic             all_on,
  input  logic             force_xs,
  input  logic [NRAIL-1:0] rail_en,
  input  logic [NRAIL-1:0] pg_s,
  output logic             xs_pin
);
  logic pg_good;
  assign pg_good = (&rail_en) && (&pg_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    xs_pin <= 1'b0;
    else if (en_s) xs_pin <= pg_good;
    else           xs_pin <= all_on && force_xs && pg_good;
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl import pwr_seq_pkg::*; #(
  parameter int         NRAIL   = 3,
  parameter int         RST_CYC = 16,
  parameter logic [7:0] DEF_TMO = 8'd200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_ok_a,
  input  logic             uvlo_a,
  input  logic             tsd_a,
  input  logic             en_pin_a,
  input  logic [NRAIL-1:0] pg_a,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [NRAIL-1:0] rail_en,
  output logic             rf_clear,
  output logic             xs_pin,
  output logic [2:0]       state_o
);
  localparam int NFLAG = 4;
  localparam int SYW   = NFLAG + NRAIL;

  logic [SYW-1:0]   sy_q;
  logic [NRAIL-1:0] pg_s;
  logic             por_s, uvlo_s, tsd_s, en_s;
  logic             all_on, force_xs;
  logic [7:0]       tmo;
  pstate_t          state;

  pwr_sync #(.W(SYW), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_a  ({pg_a, en_pin_a, tsd_a, uvlo_a, por_ok_a}),
    .q_s  (sy_q)
  );

  assign por_s  = sy_q[0];
  assign uvlo_s = sy_q[1];
  assign tsd_s  = sy_q[2];
  assign en_s   = sy_q[3];
  assign pg_s   = sy_q[SYW-1:NFLAG];

  assign rf_clear = (state == PS_OFF) || (state == PS_INIT);
  assign wr_ready = !rf_clear;

  pwr_regfile #(.NRAIL(NRAIL), .AW(8), .DW(8), .DEF_TMO(DEF_TMO)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rf_clear),
    .wr_fire (wr_valid && wr_ready),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .pg_s    (pg_s),
    .rd_data (rd_data),
    .all_on  (all_on),
    .tmo     (tmo),
    .force_xs(force_xs)
  );

  pwr_seq_fsm #(.NRAIL(NRAIL), .RST_CYC(RST_CYC), .TW(8)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .por_s  (por_s),
    .uvlo_s (uvlo_s),
    .tsd_s  (tsd_s),
    .en_req (en_s || all_on),
    .pg_s   (pg_s),
    .tmo    (tmo),
    .state_q(state),
    .rail_en(rail_en)
  );

  pwr_xs_drive #(.NRAIL(NRAIL)) u_xs (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_s    (en_s),
    .all_on  (all_on),
    .force_xs(force_xs),
    .rail_en (rail_en),
    .pg_s    (pg_s),
    .xs_pin  (xs_pin)
  );

  assign state_o = state;
endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker import pwr_seq_pkg::*; #(
  parameter int NRAIL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       state_o,
  input logic [NRAIL-1:0] rail_en,
  input logic             xs_pin
);
  // R3: rails only ever form a contiguous low-order mask
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(NRAIL'(rail_en + 1'b1)));

  // R4: running state has every rail on
  p_run_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_RUN) |-> (&rail_en));

  // R6: outside sequencing and running no rail is on
  p_rails_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != PS_SEQ && state_o != PS_RUN) |-> (rail_en == '0));

  // R6: running never falls back into sequencing directly
  p_no_reseq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_RUN) |=> (state_o != PS_SEQ));

  // R8: thermal state has all rails off
  p_hot_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_HOT) |-> (rail_en == '0));

  // R2: internal reset is entered only from the unpowered state
  p_init_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_INIT) |-> ($past(state_o) == PS_OFF || $past(state_o) == PS_INIT));

  // R9: indicator stays low unless every rail was on a cycle earlier
  p_xs_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&rail_en)) |=> !xs_pin);
endmodule

bind pwr_seq_ctrl pwr_seq_checker #(.NRAIL(NRAIL)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .state_o(state_o),
  .rail_en(rail_en),
  .xs_pin (xs_pin)
);

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;
  localparam int NRAIL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_ok_a = 1'b0, uvlo_a = 1'b0, tsd_a = 1'b0, en_pin_a = 1'b0;
  logic [NRAIL-1:0] pg_a;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
  logic [NRAIL-1:0] rail_en;
  logic rf_clear, xs_pin;
  logic [2:0] state_o;

  logic pg_auto = 1'b0;
  logic [NRAIL-1:0] pg_man = '0, pg_model = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) pg_model <= rail_en;
  assign pg_a = pg_auto ? pg_model : pg_man;

  pwr_seq_ctrl #(.NRAIL(NRAIL), .RST_CYC(16), .DEF_TMO(8'd200)) dut (
    .clk(clk), .rst_n(rst_n), .por_ok_a(por_ok_a), .uvlo_a(uvlo_a),
    .tsd_a(tsd_a), .en_pin_a(en_pin_a), .pg_a(pg_a),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rail_en(rail_en), .rf_clear(rf_clear), .xs_pin(xs_pin), .state_o(state_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic t_power_on();
    waitn(2);
    chk("R1", "state after reset", state_o, 0);
    chk("R1", "rails after reset", rail_en, 0);
    chk("R1", "ready while unpowered", wr_ready, 0);
    chk("R1", "clear while unpowered", rf_clear, 1);
    por_ok_a = 1'b1;
    waitn(4);
    chk("R2", "internal reset state", state_o, 1);
    chk("R11", "ready during internal reset", wr_ready, 0);
    waitn(20);
    chk("R2", "standby after reset window", state_o, 2);
    chk("R11", "ready in standby", wr_ready, 1);
  endtask

  task automatic t_regfile();
    logic [7:0] v;
    rd(8'h02, v);
    chk("R7", "timeout default", v, 200);
    wr(8'h03, 8'hFF);
    rd(8'h03, v);
    chk("R10", "status only bit0 writable", v, 1);
    pg_man = 3'b101;
    waitn(4);
    rd(8'h03, v);
    chk("R10", "status shows power-good bits", v, 8'h0B);
    pg_man = '0;
    wr(8'h03, 8'h00);
    wr(8'h00, 8'hFF);
    rd(8'h00, v);
    chk("R10", "unmapped write ignored", v, 0);
    wr(8'h02, 8'h5A);
    rd(8'h02, v);
    chk("R10", "timeout register write", v, 8'h5A);
    wr(8'h02, 8'd200);
  endtask

  task automatic t_sequence();
    pg_auto = 1'b0; pg_man = '0;
    en_pin_a = 1'b1;
    waitn(8);
    chk("R3", "sequencing state", state_o, 3);
    chk("R3", "first rail only", rail_en, 3'b001);
    waitn(10);
    chk("R3", "no advance without power good", rail_en, 3'b001);
    pg_man = 3'b001;
    waitn(8);
    chk("R3", "second rail", rail_en, 3'b011);
    pg_man = 3'b011;
    waitn(8);
    chk("R3", "third rail", rail_en, 3'b111);
    chk("R3", "still sequencing", state_o, 3);
    pg_man = 3'b111;
    waitn(8);
    chk("R4", "running state", state_o, 4);
    chk("R4", "all rails on", rail_en, 3'b111);
  endtask

  task automatic t_xs();
    chk("R9", "pin follows power good with EN high", xs_pin, 1);
    pg_man = 3'b011;
    waitn(6);
    chk("R9", "pin low on power-good loss, EN high", xs_pin, 0);
    pg_man = 3'b111;
    wr(8'h01, 8'h01);
    en_pin_a = 1'b0;
    waitn(6);
    chk("R3", "bus enable keeps running", state_o, 4);
    chk("R9", "pin follows FORCE=0, EN low", xs_pin, 0);
    wr(8'h03, 8'h01);
    waitn(4);
    chk("R9", "pin follows FORCE=1, EN low", xs_pin, 1);
    pg_man = 3'b011;
    waitn(6);
    chk("R9", "pin low without power good, EN low", xs_pin, 0);
    pg_man = 3'b111;
    en_pin_a = 1'b1;
    wr(8'h03, 8'h00);
    waitn(6);
    chk("R9", "FORCE ignored with EN high", xs_pin, 1);
  endtask

  task automatic t_i2c_off();
    logic [7:0] v;
    en_pin_a = 1'b0;
    waitn(6);
    chk("R6", "bus enable still holds", state_o, 4);
    wr(8'h01, 8'h00);
    waitn(6);
    chk("R6", "off command to standby", state_o, 2);
    chk("R6", "rails off after off command", rail_en, 0);
    chk("R9", "pin low when nothing enabled", xs_pin, 0);
    rd(8'h02, v);
    chk("R6", "timeout kept after off", v, 200);
  endtask

  task automatic t_uvlo();
    logic [7:0] v;
    pg_auto = 1'b1;
    wr(8'h03, 8'h01);
    en_pin_a = 1'b1;
    waitn(40);
    chk("R4", "running with following power good", state_o, 4);
    uvlo_a = 1'b1;
    waitn(6);
    chk("R6", "UVLO to standby", state_o, 2);
    chk("R6", "UVLO rails off", rail_en, 0);
    rd(8'h03, v);
    chk("R6", "FORCE kept over UVLO", v[0], 1);
    waitn(10);
    chk("R6", "no restart under UVLO", state_o, 2);
    uvlo_a = 1'b0;
    waitn(40);
    chk("R6", "restart after UVLO clears", state_o, 4);
    en_pin_a = 1'b0;
    waitn(6);
    chk("R6", "EN low to standby", state_o, 2);
  endtask

  task automatic t_timeout();
    pg_auto = 1'b0; pg_man = '0;
    wr(8'h02, 8'd10);
    en_pin_a = 1'b1;
    waitn(40);
    chk("R5", "timeout back to standby", state_o, 2);
    chk("R5", "timeout rails off", rail_en, 0);
    waitn(20);
    chk("R5", "no restart while enable held", state_o, 2);
    en_pin_a = 1'b0;
    waitn(6);
    pg_auto = 1'b1;
    en_pin_a = 1'b1;
    waitn(40);
    chk("R5", "restart after enable toggled", state_o, 4);
  endtask

  task automatic t_thermal();
    logic [7:0] v;
    tsd_a = 1'b1;
    waitn(6);
    chk("R8", "thermal state", state_o, 5);
    chk("R8", "thermal rails off", rail_en, 0);
    en_pin_a = 1'b0;
    tsd_a = 1'b0;
    waitn(8);
    chk("R8", "standby after thermal clears", state_o, 2);
    rd(8'h02, v);
    chk("R8", "timeout kept over thermal", v, 10);
  endtask

  task automatic t_por_drop();
    logic [7:0] v;
    wr(8'h01, 8'h01);
    waitn(40);
    chk("R3", "bus enable starts to running", state_o, 4);
    por_ok_a = 1'b0;
    waitn(6);
    chk("R1", "POR drop to unpowered", state_o, 0);
    chk("R1", "POR drop rails off", rail_en, 0);
    por_ok_a = 1'b1;
    waitn(26);
    chk("R2", "standby after POR returns", state_o, 2);
    rd(8'h01, v);
    chk("R7", "control reset", v, 0);
    rd(8'h02, v);
    chk("R7", "timeout reset", v, 200);
    rd(8'h03, v);
    chk("R7", "FORCE reset", v[0], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    t_power_on();
    t_regfile();
    t_sequence();
    t_xs();
    t_i2c_off();
    t_uvlo();
    t_timeout();
    t_thermal();
    t_por_drop();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule